// File: doc/BRIEF.md
# Infrared Receive Path with Carrier-Window Demodulator

This block is the receive half of a consumer-infrared controller. It watches a single IR input line, decides once per sample period whether a pulse is present, packs eight such decisions into a byte and queues the byte in a 32-entry receive FIFO. The FIFO is drained by a downstream consumer over a valid/ready stream. The consumer may hold `out_ready` low for as long as it likes. `out_valid` and `out_data` then stay put. Bytes that arrive while the FIFO is full are dropped, and the drop is reported.

When demodulation is on, a pulse only counts if the spacing of rising edges matches a programmed center period within a tolerance of n sixteenths of that period. Sixteenths are 6.25% steps, and n runs from 0 to 7. A band-select input picks the measurement rate. The high band counts every clock, and the low band counts one tick every `LS_PRE` clocks, so one center setting serves both the slow and the fast carrier families. When demodulation is off, the synchronized input level is taken as the pulse decision directly.

Status comes out on plain pins:
- a receiver-active level;
- a data-stale timeout;
- a 3-bit interrupt identification code, which reports the highest-priority enabled cause, together with an interrupt request line.

Top module: `ir_rx_demod`

## Requirements
- R1: With `rx_en` high, the block takes one sample every `SAMPLE_DIV` clocks. Eight samples form a byte, with the earliest sample in bit 7 and the latest in bit 0. A bit is 1 when a pulse was seen. Each completed byte is pushed into the FIFO.
- R2: While `rx_en` is low, nothing is sampled and no byte is produced. A partly built byte is discarded when `rx_en` falls.
- R3: With `demod_en` low, the pulse decision is the input level after a two-flop synchronizer.
- R4: With `demod_en` high, a rising edge sets the pulse decision when its measured spacing P from the previous rising edge satisfies |P - C| <= (C*n)>>4, where C is `center` in ticks and n is `range_n` (0..7). A rising edge whose spacing fails this test clears the decision.
- R5: In the high band (`hs_sel`=1) a tick is one clock. In the low band (`hs_sel`=0) a tick is `LS_PRE` clocks.
- R6: A locked pulse decision is dropped once more than 2*C ticks pass with no rising edge.
- R7: `rx_active` equals the current pulse decision.
- R8: With `idle_mode` high, completed bytes equal to 8'h00 are not stored; all other bytes are stored.
- R9: The FIFO holds `FIFO_DEPTH` (32) bytes in arrival order. `fifo_count` is 6 bits wide. `out_valid` is high whenever the count is nonzero, and a byte leaves on a cycle with `out_valid` and `out_ready` both high.
- R10: A byte that arrives while the FIFO is full, with no pop in the same cycle, is dropped. The overrun flag it sets stays until `iid_rd` is pulsed.
- R11: `fifo_timeout` rises once the FIFO has been non-empty with no pop for `TO_CYCLES` consecutive clocks. A pop, or an empty FIFO, clears it on the next clock.
- R12: The `iid` output is {cause[1:0], pending}. The cause codes are 00 none, 01 transmit-low, 10 receive data, 11 overrun. Enables are `ie[0]` transmit-low, `ie[1]` receive data and `ie[2]` overrun. Priority runs overrun, then data, then transmit-low. `irq` equals the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Raw IR line, high while carrier/light present |
| rx_en | input | 1 | Receiver enable, gates all sampling |
| demod_en | input | 1 | Carrier-window check enable |
| hs_sel | input | 1 | Band select: 1 high band, 0 low band |
| range_n | input | 3 | Tolerance n, in sixteenths of the center |
| center | input | 8 | Center carrier period in ticks |
| idle_mode | input | 1 | Drop all-space bytes while high |
| ie | input | 3 | Interrupt cause enables |
| tx_low | input | 1 | Transmit-low-level condition from the transmit side |
| iid_rd | input | 1 | One-cycle pulse: identification read, clears overrun |
| out_valid | output | 1 | FIFO head byte valid |
| out_ready | input | 1 | Consumer accepts head byte |
| out_data | output | 8 | FIFO head byte |
| fifo_count | output | 6 | Bytes held in the FIFO |
| rx_active | output | 1 | Current pulse decision |
| fifo_timeout | output | 1 | Data left unread too long |
| iid | output | 3 | Interrupt identification {cause, pending} |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the edges of the carrier window. It uses spacings exactly on the tolerance limit and one tick beyond it. It uses n = 0, which demands an exact match. It sends a carrier from the other band, which must fail the check. A wrong tolerance width or a rounding slip turns an expected 8'hFF into 8'h00, or the reverse. The bench also sends carrier bursts that start and stop within a byte. A design that holds a lock too long or acquires it too late gives a byte other than 8'hF0 or 8'h3C. Further tests fill the FIFO one byte past full, read the identification and check the timeout on both sides of its limit. A design that overwrote on overrun, cleared the flag early or mis-ordered the priorities shows a wrong count, a wrong head byte or a wrong `iid` code.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_TXLOW  = 2'b01,
    CAUSE_RXDATA = 2'b10,
    CAUSE_OVR    = 2'b11
  } iid_cause_e;

  localparam int IE_TXLOW  = 0;
  localparam int IE_RXDATA = 1;
  localparam int IE_OVR    = 2;
endpackage

// File: rtl/ir_carrier_meas.sv
module ir_carrier_meas #(
  parameter int LS_PRE  = 2,
  parameter int PER_W   = 10,
  parameter int CTR_W   = 8,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  input  logic             hs_sel,
  input  logic             demod_en,
  input  logic [2:0]       range_n,
  input  logic [CTR_W-1:0] center,
  output logic             det
);
  localparam int CMP_W = ((PER_W + 1) > (CTR_W + 3)) ? (PER_W + 1) : (CTR_W + 3);
  localparam int PRE_W = (LS_PRE > 1) ? $clog2(LS_PRE) : 1;

  // input synchronizer chain
  logic [SYNC_N:0] sync_q;
  assign sync_q[0] = ir_in;
  for (genvar g = 0; g < SYNC_N; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g+1] <= 1'b0;
      else        sync_q[g+1] <= sync_q[g];
    end
  end

  logic lvl, lvl_d, rise;
  assign lvl = sync_q[SYNC_N];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end
  assign rise = lvl & ~lvl_d;

  // tick generation: one per clock in the high band, prescaled in the low band
  logic tick;
  if (LS_PRE > 1) begin : g_pre
    logic [PRE_W-1:0] pre_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             pre_q <= '0;
      else if (pre_q == PRE_W'(LS_PRE - 1))   pre_q <= '0;
      else                                    pre_q <= pre_q + 1'b1;
    end
    assign tick = hs_sel | (pre_q == PRE_W'(LS_PRE - 1));
  end else begin : g_nopre
    assign tick = 1'b1;
  end

  // edge spacing measurement
  logic [PER_W-1:0] per_q;
  logic [CMP_W-1:0] meas, ctr_x, tol, diff;
  logic             in_win, too_long;
  logic             lock_q;

  always_comb begin
    meas = CMP_W'(per_q) + CMP_W'(tick);
    ctr_x = CMP_W'(center);
    tol  = (CMP_W'(center) * CMP_W'(range_n)) >> 4;
    diff = (meas > ctr_x) ? (meas - ctr_x) : (ctr_x - meas);
    in_win   = (diff <= tol);
    too_long = (CMP_W'(per_q) > (ctr_x << 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      lock_q <= 1'b0;
    end else if (rise) begin
      per_q  <= '0;
      lock_q <= in_win;
    end else begin
      if (tick && (per_q != '1)) per_q <= per_q + 1'b1;
      if (too_long)              lock_q <= 1'b0;
    end
  end

  assign det = demod_en ? lock_q : lvl;

  AST_LOCK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(rise)); // R4
  AST_NO_LOCK_LONG_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && CMP_W'(per_q) > (CMP_W'(center) << 1)) |=> !lock_q || $past(rise)); // R6
endmodule

// File: rtl/ir_sample_pack.sv
module ir_sample_pack #(
  parameter int SAMPLE_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       idle_mode,
  input  logic       det,
  output logic       byte_v,
  output logic [7:0] byte_q
);
  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [6:0]       sh_q;
  logic             stb;
  logic [7:0]       full_byte;

  assign stb       = rx_en && (div_q == DIV_W'(SAMPLE_DIV - 1));
  assign full_byte = {sh_q, det};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      byte_v <= 1'b0;
      byte_q <= '0;
    end else if (!rx_en) begin
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      byte_v <= 1'b0;
    end else begin
      byte_v <= 1'b0;
      if (stb) begin
        div_q <= '0;
        bit_q <= bit_q + 1'b1;
        sh_q  <= full_byte[6:0];
        if (bit_q == 3'd7) begin
          byte_q <= full_byte;
          byte_v <= !(idle_mode && (full_byte == 8'h00));
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (div_q == '0) && !byte_v); // R2
  AST_IDLE_NO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_v |-> (byte_q != 8'h00) || !$past(idle_mode)); // R8
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic [CW-1:0] count,
  output logic          pop,
  output logic          ovr_evt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic          full, push_ok;

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready;
  assign push_ok   = push && (!full || pop);
  assign ovr_evt   = push && !push_ok;
  assign out_data  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)     rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R9
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R9
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (count == CW'(DEPTH))); // R10
endmodule

// File: rtl/ir_rx_irq.sv
module ir_rx_irq
  import ir_rx_pkg::*;
#(
  parameter int TO_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovr_evt,
  input  logic       nonempty,
  input  logic       pop,
  input  logic       tx_low,
  input  logic [2:0] ie,
  input  logic       iid_rd,
  output logic       fifo_timeout,
  output logic [2:0] iid,
  output logic       irq
);
  localparam int TO_W = (TO_CYCLES > 1) ? $clog2(TO_CYCLES) : 1;

  logic            ovr_q;
  logic [TO_W-1:0] to_cnt_q;
  iid_cause_e      cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ovr_evt) ovr_q <= 1'b1;
    else if (iid_rd)  ovr_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_cnt_q     <= '0;
      fifo_timeout <= 1'b0;
    end else if (!nonempty || pop) begin
      to_cnt_q     <= '0;
      fifo_timeout <= 1'b0;
    end else if (to_cnt_q == TO_W'(TO_CYCLES - 1)) begin
      fifo_timeout <= 1'b1;
    end else begin
      to_cnt_q <= to_cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (ovr_q && ie[IE_OVR])               cause = CAUSE_OVR;
    else if (nonempty && ie[IE_RXDATA])    cause = CAUSE_RXDATA;
    else if (tx_low && ie[IE_TXLOW])       cause = CAUSE_TXLOW;
    else                                   cause = CAUSE_NONE;
  end

  assign iid = {cause, cause != CAUSE_NONE};
  assign irq = iid[0];

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !iid_rd) |=> ovr_q); // R10
  AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !fifo_timeout); // R11
  AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 3'b000) |-> !irq); // R12
endmodule

// File: rtl/ir_rx_demod.sv
module ir_rx_demod #(
  parameter int SAMPLE_DIV = 64,
  parameter int LS_PRE     = 2,
  parameter int FIFO_DEPTH = 32,
  parameter int TO_CYCLES  = 4096,
  parameter int PER_W      = 10,
  parameter int CTR_W      = 8,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  input  logic             rx_en,
  input  logic             demod_en,
  input  logic             hs_sel,
  input  logic [2:0]       range_n,
  input  logic [CTR_W-1:0] center,
  input  logic             idle_mode,
  input  logic [2:0]       ie,
  input  logic             tx_low,
  input  logic             iid_rd,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic [CNT_W-1:0] fifo_count,
  output logic             rx_active,
  output logic             fifo_timeout,
  output logic [2:0]       iid,
  output logic             irq
);
  logic       det;
  logic       byte_v;
  logic [7:0] byte_q;
  logic       pop, ovr_evt;

  ir_carrier_meas #(
    .LS_PRE (LS_PRE),
    .PER_W  (PER_W),
    .CTR_W  (CTR_W),
    .SYNC_N (2)
  ) u_meas (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_in    (ir_in),
    .hs_sel   (hs_sel),
    .demod_en (demod_en),
    .range_n  (range_n),
    .center   (center),
    .det      (det)
  );

  ir_sample_pack #(
    .SAMPLE_DIV (SAMPLE_DIV)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .idle_mode (idle_mode),
    .det       (det),
    .byte_v    (byte_v),
    .byte_q    (byte_q)
  );

  ir_rx_fifo #(
    .DEPTH (FIFO_DEPTH),
    .CW    (CNT_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (byte_v),
    .push_data (byte_q),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .count     (fifo_count),
    .pop       (pop),
    .ovr_evt   (ovr_evt)
  );

  ir_rx_irq #(
    .TO_CYCLES (TO_CYCLES)
  ) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovr_evt      (ovr_evt),
    .nonempty     (out_valid),
    .pop          (pop),
    .tx_low       (tx_low),
    .ie           (ie),
    .iid_rd       (iid_rd),
    .fifo_timeout (fifo_timeout),
    .iid          (iid),
    .irq          (irq)
  );

  assign rx_active = det;

  AST_ACTIVE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (!demod_en && !$past(ir_in) && !$past(ir_in, 2) && !$past(ir_in, 3)) |-> !rx_active); // R7
endmodule

// File: tb/ir_rx_demod_tb.sv
module ir_rx_demod_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SDIV  = 64;
  localparam int TO_CY = 2000;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_in = 1'b0, rx_en = 1'b0, demod_en = 1'b0, hs_sel = 1'b0;
  logic [2:0] range_n = 3'd1;
  logic [7:0] center = 8'd16;
  logic idle_mode = 1'b0;
  logic [2:0] ie = 3'b000;
  logic tx_low = 1'b0, iid_rd = 1'b0, out_ready = 1'b0;
  logic out_valid, rx_active, fifo_timeout, irq;
  logic [7:0] out_data;
  logic [5:0] fifo_count;
  logic [2:0] iid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_rx_demod #(
    .SAMPLE_DIV (SDIV),
    .LS_PRE     (2),
    .FIFO_DEPTH (DEPTH),
    .TO_CYCLES  (TO_CY)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .ir_in (ir_in), .rx_en (rx_en),
    .demod_en (demod_en), .hs_sel (hs_sel), .range_n (range_n),
    .center (center), .idle_mode (idle_mode), .ie (ie), .tx_low (tx_low),
    .iid_rd (iid_rd), .out_valid (out_valid), .out_ready (out_ready),
    .out_data (out_data), .fifo_count (fifo_count), .rx_active (rx_active),
    .fifo_timeout (fifo_timeout), .iid (iid), .irq (irq)
  );

  // vector: {demod[28], hs[27], rng[26:24], per[23:16], pat[15:8], exp[7:0]}
  // per = carrier period in clocks, 0 = raw level drive
  localparam int NVEC = 12;
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 3'd1, 8'd0,  8'hA5, 8'hA5},  // R1 R3 raw
    {1'b0, 1'b0, 3'd1, 8'd0,  8'h3C, 8'h3C},  // R1 R3 raw
    {1'b1, 1'b0, 3'd1, 8'd32, 8'hFF, 8'hFF},  // R4 R5 exact center low band
    {1'b1, 1'b0, 3'd1, 8'd40, 8'hFF, 8'h00},  // R4 20 ticks vs 16+-1
    {1'b1, 1'b0, 3'd4, 8'd40, 8'hFF, 8'hFF},  // R4 tol 4, on limit
    {1'b1, 1'b0, 3'd3, 8'd40, 8'hFF, 8'h00},  // R4 tol 3, one past
    {1'b1, 1'b0, 3'd2, 8'd28, 8'hFF, 8'hFF},  // R4 below center on limit
    {1'b1, 1'b1, 3'd1, 8'd16, 8'hF0, 8'hF0},  // R5 R6 high band burst
    {1'b1, 1'b1, 3'd7, 8'd32, 8'hFF, 8'h00},  // R5 low carrier in high band
    {1'b1, 1'b0, 3'd7, 8'd16, 8'hFF, 8'h00},  // R5 high carrier in low band
    {1'b1, 1'b0, 3'd1, 8'd32, 8'h3C, 8'h3C},  // R6 burst mid-byte
    {1'b1, 1'b0, 3'd0, 8'd32, 8'hFF, 8'hFF}   // R4 n=0 exact
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive 8 sample windows; bit 7 first
  task automatic drive_bits(input logic [7:0] pat, input int per);
    for (int k = 0; k < 8*SDIV; k++) begin
      logic b;
      b = pat[7 - k/SDIV];
      if (per == 0) ir_in = b;
      else          ir_in = b && ((k % per) < (per/2));
      @(negedge clk);
    end
    ir_in = 1'b0;
  endtask

  task automatic one_byte(input logic [7:0] pat, input int per);
    ir_in = 1'b0;
    cyc(200);
    rx_en = 1'b1;
    drive_bits(pat, per);
    cyc(4);
    rx_en = 1'b0;
    cyc(1);
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string tag);
    chk(out_valid == 1'b1, {tag, " valid"}, out_valid, 1);
    chk(out_data == exp, tag, out_data, exp);
    out_ready = 1'b1;
    cyc(1);
    out_ready = 1'b0;
  endtask

  task automatic flush();
    while (out_valid) begin
      out_ready = 1'b1;
      cyc(1);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
    chk(fifo_count == 6'd0, "R9 reset count", fifo_count, 0);
    chk(iid == 3'b000, "R12 reset iid", iid, 0);
    chk(rx_active == 1'b0, "R7 reset active", rx_active, 0);
    rst_n = 1'b1;
    cyc(2);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      demod_en = VEC[i][28];
      hs_sel   = VEC[i][27];
      range_n  = VEC[i][26:24];
      one_byte(VEC[i][15:8], int'(VEC[i][23:16]));
      pop_chk(VEC[i][7:0], $sformatf("R4 vec%0d", i));
      flush();
    end
    demod_en = 1'b0; hs_sel = 1'b0; range_n = 3'd1;

    // R7 raw activity follows input
    ir_in = 1'b1; cyc(4);
    chk(rx_active == 1'b1, "R7 active high", rx_active, 1);
    ir_in = 1'b0; cyc(4);
    chk(rx_active == 1'b0, "R7 active low", rx_active, 0);

    // R2 disabled: toggling input stores nothing
    for (int k = 0; k < 1000; k++) begin ir_in = k[3]; cyc(1); end
    ir_in = 1'b0;
    chk(fifo_count == 6'd0, "R2 disabled count", fifo_count, 0);
    // R2 partial byte discarded
    rx_en = 1'b1; ir_in = 1'b1; cyc(4*SDIV);
    rx_en = 1'b0; ir_in = 1'b0; cyc(10);
    chk(fifo_count == 6'd0, "R2 partial count", fifo_count, 0);
    one_byte(8'h00, 0);
    pop_chk(8'h00, "R2 fresh byte after disable");

    // R8 idle mode
    idle_mode = 1'b1;
    one_byte(8'h00, 0);
    chk(fifo_count == 6'd0, "R8 space dropped", fifo_count, 0);
    one_byte(8'h81, 0);
    pop_chk(8'h81, "R8 non-space kept");
    idle_mode = 1'b0;

    // R9 ordering
    cyc(200);
    rx_en = 1'b1;
    drive_bits(8'hA5, 0);
    drive_bits(8'h3C, 0);
    cyc(4); rx_en = 1'b0; cyc(1);
    chk(fifo_count == 6'd2, "R9 two bytes", fifo_count, 2);
    pop_chk(8'hA5, "R9 order first");
    pop_chk(8'h3C, "R9 order second");

    // R10 fill past full
    ie = 3'b110; tx_low = 1'b0;
    rx_en = 1'b1; ir_in = 1'b1;
    cyc(DEPTH*8*SDIV + 4);
    chk(fifo_count == 6'd32, "R9 full count", fifo_count, 32);
    chk(iid == 3'b101, "R12 data iid", iid, 3'b101);
    cyc(8*SDIV);
    rx_en = 1'b0; ir_in = 1'b0; cyc(2);
    chk(fifo_count == 6'd32, "R10 dropped count", fifo_count, 32);
    chk(iid == 3'b111, "R10 overrun iid", iid, 3'b111);
    chk(irq == 1'b1, "R12 irq", irq, 1);
    cyc(20);
    chk(iid == 3'b111, "R10 overrun sticky", iid, 3'b111);
    iid_rd = 1'b1; cyc(1); iid_rd = 1'b0;
    chk(iid == 3'b101, "R10 cleared by read", iid, 3'b101);
    pop_chk(8'hFF, "R10 head kept");
    chk(fifo_count == 6'd31, "R10 count after pop", fifo_count, 31);
    flush();

    // R12 priority and masking
    tx_low = 1'b1; ie = 3'b111; cyc(1);
    chk(iid == 3'b011, "R12 txlow only", iid, 3'b011);
    ie = 3'b000; cyc(1);
    chk(iid == 3'b000 && irq == 1'b0, "R12 masked", iid, 0);

    // R11 timeout
    ie = 3'b101;
    one_byte(8'h81, 0);
    chk(iid == 3'b011, "R12 rx masked gives txlow", iid, 3'b011);
    cyc(1500);
    chk(fifo_timeout == 1'b0, "R11 before limit", fifo_timeout, 0);
    cyc(600);
    chk(fifo_timeout == 1'b1, "R11 after limit", fifo_timeout, 1);
    pop_chk(8'h81, "R11 stale byte");
    chk(fifo_timeout == 1'b0, "R11 cleared by pop", fifo_timeout, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule